// File: doc/BRIEF.md
# DDR2 Column Data-Window Scheduler

This block belongs to the data path of a DDR2 memory controller. Each clock edge it may take one column command, a read or a write. From the programmed CAS latency, additive latency and burst length, it works out in which clock cycles the shared data bus is busy. A read opens a capture window and a write opens a drive window. In every cycle of a window the block reports the index of the first beat carried in that cycle. Data moves on both clock edges, so each window cycle carries two beats. A write window also carries a byte-mask enable, and a command that asked for auto-precharge gets a one-cycle notice just after its burst ends.

Read latency is the additive latency plus the CAS latency. Write latency is one cycle less than read latency. A command whose window would overlap any window already booked is still scheduled, but the block raises an error pulse for it. The timing settings can be changed only while no burst is pending. A change requested at any other time is dropped, and so is a change with an illegal value.

Top module: `ddr2_lat_sched`

## Requirements
- R1: A configuration load accepts a CAS latency of 3 to 7 cycles. A load with a CAS latency outside that range, or an additive latency above 4, is dropped, and the previous settings stay in force.
- R2: The additive latency can be programmed from 0 to 4. The burst-length select `cfg_bl8` chooses 8 beats (4 bus cycles) when it is 1 and 4 beats (2 bus cycles) when it is 0.
- R3: A read accepted at clock edge k drives `rd_win` high for the cycles that start at edges k+RL through k+RL+BL/2-1, where RL = AL + CL.
- R4: A write accepted at edge k drives `wr_win` high for the cycles that start at edges k+WL through k+WL+BL/2-1, where WL = RL - 1.
- R5: In the n-th cycle of a window (n counted from 0), the beat output is 2n. Outside a window the beat output is 0.
- R6: `wr_mask_en` is high in exactly those write-window cycles that belong to a write issued with `cmd_mask` = 1.
- R7: When a command was issued with `cmd_ap` = 1, `rd_ap_done` or `wr_ap_done` (matching its type) is high for one cycle, starting at the edge after its last window cycle.
- R8: If a command accepted at edge k has a window that overlaps any window already booked, of either type, then `sched_err` is high in the cycle after edge k. Otherwise `sched_err` stays low.
- R9: A configuration load takes effect only when no window or auto-precharge notice is pending and `cmd_valid` is low at that edge. Otherwise the load is ignored.
- R10: After reset all outputs are low, and the settings are CL = 3, AL = 0 and 4-beat bursts.
- R11: Commands of one type issued BL/2 cycles apart give windows that join end to end, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Request to load the timing settings |
| cfg_cl | input | 3 | CAS latency to load |
| cfg_al | input | 3 | Additive latency to load |
| cfg_bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cmd_valid | input | 1 | A column command is present this edge |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_ap | input | 1 | The command requests auto-precharge |
| cmd_mask | input | 1 | The write's byte mask is to be driven |
| rd_win | output | 1 | Read capture window |
| rd_beat | output | 3 | First beat index of this read cycle |
| rd_ap_done | output | 1 | Read auto-precharge notice |
| wr_win | output | 1 | Write drive window |
| wr_beat | output | 3 | First beat index of this write cycle |
| wr_mask_en | output | 1 | Byte-mask drive enable |
| wr_ap_done | output | 1 | Write auto-precharge notice |
| sched_err | output | 1 | Window-overlap error pulse |

## Verification
The in-line assertions check four things on every cycle:
- Settings never change while a burst is pending, and the read latency stays within its legal range.
- Every auto-precharge notice directly follows a window cycle.
- A rising window always reports beat 0.
- An error pulse only ever follows an accepted command.

The exact start cycle of each window under every CL, AL and burst-length combination can only be shown by the bench's reference model, together with window lengths, mask placement, overlap detection and the dropping of illegal or badly timed configuration loads.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;
   localparam int unsigned DFLT_CL_MIN = 3;
   localparam int unsigned DFLT_CL_MAX = 7;
   localparam int unsigned DFLT_AL_MAX = 4;
   localparam int unsigned DFLT_BL_MAX = 8;

   typedef enum logic {
      LANE_RD = 1'b0,
      LANE_WR = 1'b1
   } lane_e;
endpackage

// File: rtl/ddr2_lat_cfg.sv
module ddr2_lat_cfg #(
   parameter int unsigned CL_MIN = 3,
   parameter int unsigned CL_MAX = 7,
   parameter int unsigned AL_MAX = 4,
   parameter int unsigned BC_MAX = 4,
   parameter int unsigned CLW    = 3,
   parameter int unsigned ALW    = 3,
   parameter int unsigned LW     = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [CLW-1:0] cl_in,
   input  logic [ALW-1:0] al_in,
   input  logic           bl8_in,
   input  logic           idle,
   output logic [LW-1:0]  rl,
   output logic [LW-1:0]  wl,
   output logic [LW-1:0]  bc
);
   localparam int unsigned RL_MAX = CL_MAX + AL_MAX;

   logic [LW-1:0] rl_q, bc_q;
   logic          legal;
   logic [LW-1:0] rl_new, bc_new;

   always_comb begin
      legal  = (int'(cl_in) >= int'(CL_MIN)) && (int'(cl_in) <= int'(CL_MAX))
               && (int'(al_in) <= int'(AL_MAX));
      rl_new = LW'(cl_in) + LW'(al_in);
      bc_new = bl8_in ? LW'(BC_MAX) : LW'(BC_MAX / 2);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rl_q <= LW'(CL_MIN);
         bc_q <= LW'(BC_MAX / 2);
      end else if (load && idle && legal) begin
         rl_q <= rl_new;
         bc_q <= bc_new;
      end
   end

   assign rl = rl_q;
   assign wl = rl_q - LW'(1);
   assign bc = bc_q;

   // R9: settings frozen while anything is pending
   a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(rl_q) && $stable(bc_q)));

   // R1: read latency stays inside the legal range
   a_r1_rl_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rl_q) >= int'(CL_MIN)) && (int'(rl_q) <= int'(RL_MAX)));
endmodule

// File: rtl/ddr2_burst_lane.sv
module ddr2_burst_lane #(
   parameter int unsigned W   = 16,
   parameter int unsigned LW  = 4,
   parameter int unsigned BCW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [LW-1:0]  lat,
   input  logic [LW-1:0]  ncyc,
   input  logic           ap_in,
   input  logic           mk_in,
   output logic           win,
   output logic [BCW-1:0] jidx,
   output logic           mk_out,
   output logic           ap_out,
   output logic           busy,
   output logic [W-1:0]   ahead,
   output logic [W-1:0]   newmap
);
   logic [W-1:0]   occ_q, mk_q, ap_q;
   logic [W-1:0]   occ_n, mk_n, ap_n, mk_sh, ap_sh;
   logic [BCW-1:0] jv_q [W];
   logic [BCW-1:0] jv_n [W];

   always_comb begin
      ahead = occ_q >> 1;
      mk_sh = mk_q >> 1;
      ap_sh = ap_q >> 1;
      for (int i = 0; i < int'(W); i++) begin
         newmap[i] = push && (i >= int'(lat)) && (i < int'(lat) + int'(ncyc));
      end
      occ_n = ahead | newmap;
      for (int i = 0; i < int'(W); i++) begin
         mk_n[i] = newmap[i] ? mk_in : mk_sh[i];
         ap_n[i] = ap_sh[i] | (push && ap_in && (i == int'(lat) + int'(ncyc)));
      end
      for (int i = 0; i < int'(W) - 1; i++) begin
         jv_n[i] = newmap[i] ? BCW'(i - int'(lat)) : jv_q[i+1];
      end
      jv_n[W-1] = newmap[W-1] ? BCW'(int'(W) - 1 - int'(lat)) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         mk_q  <= '0;
         ap_q  <= '0;
         for (int i = 0; i < int'(W); i++) jv_q[i] <= '0;
      end else begin
         occ_q <= occ_n;
         mk_q  <= mk_n;
         ap_q  <= ap_n;
         for (int i = 0; i < int'(W); i++) jv_q[i] <= jv_n[i];
      end
   end

   assign win    = occ_q[0];
   assign jidx   = jv_q[0];
   assign mk_out = mk_q[0];
   assign ap_out = ap_q[0];
   assign busy   = (|occ_q) | (|ap_q);

   // R7: a precharge notice only ever follows a window cycle
   a_r7_ap_follows_win: assert property (@(posedge clk) disable iff (!rst_n)
      ap_out |-> $past(win));

   // R5: the first cycle of a window reports beat zero
   a_r5_start_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win) |-> (jidx == '0));
endmodule

// File: rtl/ddr2_lat_sched.sv
module ddr2_lat_sched
   import ddr2_sched_pkg::*;
#(
   parameter int unsigned CL_MIN = DFLT_CL_MIN,
   parameter int unsigned CL_MAX = DFLT_CL_MAX,
   parameter int unsigned AL_MAX = DFLT_AL_MAX,
   parameter int unsigned BL_MAX = DFLT_BL_MAX,
   localparam int unsigned CLW   = $clog2(CL_MAX + 1),
   localparam int unsigned ALW   = $clog2(AL_MAX + 1),
   localparam int unsigned BIW   = $clog2(BL_MAX)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_load,
   input  logic [CLW-1:0] cfg_cl,
   input  logic [ALW-1:0] cfg_al,
   input  logic           cfg_bl8,
   input  logic           cmd_valid,
   input  logic           cmd_write,
   input  logic           cmd_ap,
   input  logic           cmd_mask,
   output logic           rd_win,
   output logic [BIW-1:0] rd_beat,
   output logic           rd_ap_done,
   output logic           wr_win,
   output logic [BIW-1:0] wr_beat,
   output logic           wr_mask_en,
   output logic           wr_ap_done,
   output logic           sched_err
);
   localparam int unsigned RL_MAX = CL_MAX + AL_MAX;
   localparam int unsigned BC_MAX = BL_MAX / 2;
   localparam int unsigned W      = RL_MAX + BC_MAX + 1;
   localparam int unsigned LW     = $clog2(W);
   localparam int unsigned BCW    = BIW - 1;

   if (CL_MIN < 2) begin : g_bad_clmin
      $error("CL_MIN must leave a write latency of at least one cycle");
   end
   if (CL_MAX < CL_MIN) begin : g_bad_clmax
      $error("CL_MAX below CL_MIN");
   end
   if ((BL_MAX % 4) != 0) begin : g_bad_bl
      $error("BL_MAX must be a multiple of four");
   end

   logic [LW-1:0]  rl, wl, bc;
   logic           idle;
   logic           l_win  [2];
   logic [BCW-1:0] l_jidx [2];
   logic           l_mk   [2];
   logic           l_ap   [2];
   logic           l_busy [2];
   logic [W-1:0]   l_ahd  [2];
   logic [W-1:0]   l_new  [2];
   logic [W-1:0]   clash;
   logic           err_q;

   assign idle = !l_busy[LANE_RD] && !l_busy[LANE_WR] && !cmd_valid;

   ddr2_lat_cfg #(
      .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX), .BC_MAX(BC_MAX),
      .CLW(CLW), .ALW(ALW), .LW(LW)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .cl_in(cfg_cl),
      .al_in(cfg_al), .bl8_in(cfg_bl8), .idle(idle),
      .rl(rl), .wl(wl), .bc(bc)
   );

   for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam bit IS_WR = (g == 1);
      ddr2_burst_lane #(.W(W), .LW(LW), .BCW(BCW)) u_lane (
         .clk(clk), .rst_n(rst_n),
         .push(cmd_valid && (cmd_write == IS_WR)),
         .lat(IS_WR ? wl : rl),
         .ncyc(bc),
         .ap_in(cmd_ap),
         .mk_in(IS_WR ? cmd_mask : 1'b0),
         .win(l_win[g]), .jidx(l_jidx[g]), .mk_out(l_mk[g]),
         .ap_out(l_ap[g]), .busy(l_busy[g]),
         .ahead(l_ahd[g]), .newmap(l_new[g])
      );
   end

   assign clash = (l_new[LANE_RD] | l_new[LANE_WR]) & (l_ahd[LANE_RD] | l_ahd[LANE_WR]);

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= |clash;
   end

   assign rd_win     = l_win[LANE_RD];
   assign rd_beat    = {l_jidx[LANE_RD], 1'b0};
   assign rd_ap_done = l_ap[LANE_RD];
   assign wr_win     = l_win[LANE_WR];
   assign wr_beat    = {l_jidx[LANE_WR], 1'b0};
   assign wr_mask_en = l_mk[LANE_WR];
   assign wr_ap_done = l_ap[LANE_WR];
   assign sched_err  = err_q;

   // R8: an overlap pulse always follows an accepted command
   a_r8_err_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      sched_err |-> $past(cmd_valid));
endmodule

// File: tb/ddr2_lat_sched_bench.sv
module ddr2_lat_sched_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0, cfg_bl8 = 1'b0;
   logic [2:0] cfg_cl = 3'd0, cfg_al = 3'd0;
   logic       cmd_valid = 1'b0, cmd_write = 1'b0, cmd_ap = 1'b0, cmd_mask = 1'b0;
   logic       rd_win, rd_ap_done, wr_win, wr_mask_en, wr_ap_done, sched_err;
   logic [2:0] rd_beat, wr_beat;

   ddr2_lat_sched u_ddr2_lat_sched (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cl(cfg_cl),
      .cfg_al(cfg_al), .cfg_bl8(cfg_bl8), .cmd_valid(cmd_valid),
      .cmd_write(cmd_write), .cmd_ap(cmd_ap), .cmd_mask(cmd_mask),
      .rd_win(rd_win), .rd_beat(rd_beat), .rd_ap_done(rd_ap_done),
      .wr_win(wr_win), .wr_beat(wr_beat), .wr_mask_en(wr_mask_en),
      .wr_ap_done(wr_ap_done), .sched_err(sched_err)
   );

   always #2 clk = ~clk;

   int    cyc = 0;
   int    checks = 0;
   int    errs = 0;
   bit    chk_on = 1'b0;
   string scen = "reset";

   // reference model: expected values per absolute cycle
   bit exp_rw [int];
   bit exp_ww [int];
   int exp_rb [int];
   int exp_wb [int];
   bit exp_wm [int];
   bit exp_ra [int];
   bit exp_wa [int];
   bit exp_er [int];
   int m_cl = 3, m_al = 0;
   bit m_bl8 = 1'b0;
   int last_busy = -100;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", req, scen, cyc, act, expv);
      end
   endtask

   function automatic int getb(input bit a [int], input int c);
      return a.exists(c) ? int'(a[c]) : 0;
   endfunction
   function automatic int geti(input int a [int], input int c);
      return a.exists(c) ? a[c] : 0;
   endfunction

   always @(negedge clk) begin
      if (chk_on) begin
         check(rd_win == getb(exp_rw, cyc), "R3 rd_win", rd_win, getb(exp_rw, cyc));
         check(wr_win == getb(exp_ww, cyc), "R4 wr_win", wr_win, getb(exp_ww, cyc));
         check(rd_beat == geti(exp_rb, cyc), "R5 rd_beat", rd_beat, geti(exp_rb, cyc));
         check(wr_beat == geti(exp_wb, cyc), "R5 wr_beat", wr_beat, geti(exp_wb, cyc));
         check(wr_mask_en == getb(exp_wm, cyc), "R6 wr_mask_en", wr_mask_en, getb(exp_wm, cyc));
         check(rd_ap_done == getb(exp_ra, cyc), "R7 rd_ap_done", rd_ap_done, getb(exp_ra, cyc));
         check(wr_ap_done == getb(exp_wa, cyc), "R7 wr_ap_done", wr_ap_done, getb(exp_wa, cyc));
         check(sched_err == getb(exp_er, cyc), "R8 sched_err", sched_err, getb(exp_er, cyc));
      end
   end

   // one clock of stimulus; the model books what the edge k = cyc+1 produces
   task automatic step(input bit v, input bit w, input bit ap, input bit mk,
                       input bit ld, input int cl, input int al, input bit b8);
      int k, lat, n, c;
      bit hit;
      @(negedge clk);
      cmd_valid = v; cmd_write = w; cmd_ap = ap; cmd_mask = mk;
      cfg_load = ld; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl8 = b8;
      k = cyc + 1;
      if (v) begin
         lat = m_al + m_cl - (w ? 1 : 0);
         n   = m_bl8 ? 4 : 2;
         hit = 1'b0;
         for (int j = 0; j < n; j++) begin
            c = k + lat + j;
            if (exp_rw.exists(c) || exp_ww.exists(c)) hit = 1'b1;
         end
         for (int j = 0; j < n; j++) begin
            c = k + lat + j;
            if (w) begin
               exp_ww[c] = 1'b1; exp_wb[c] = 2 * j; exp_wm[c] = mk;
            end else begin
               exp_rw[c] = 1'b1; exp_rb[c] = 2 * j;
            end
         end
         if (ap) begin
            if (w) exp_wa[k + lat + n] = 1'b1;
            else   exp_ra[k + lat + n] = 1'b1;
         end
         if (hit) exp_er[k] = 1'b1;
         if (k + lat + n > last_busy) last_busy = k + lat + n;
      end else if (ld && last_busy < k - 1 && cl >= 3 && cl <= 7 && al <= 4) begin
         m_cl = cl; m_al = al; m_bl8 = b8;   // R9, R1, R2
      end
   endtask

   task automatic idle_n(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic drain();
      while (last_busy >= cyc - 1) idle_n(1);
      idle_n(1);
   endtask

   task automatic load(input int cl, input int al, input bit b8);
      drain();
      step(0, 0, 0, 0, 1, cl, al, b8);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state of all outputs
      check({rd_win, wr_win, rd_ap_done, wr_ap_done, wr_mask_en, sched_err} == 6'b0,
            "R10 outputs in reset", {rd_win, wr_win, rd_ap_done, wr_ap_done, wr_mask_en, sched_err}, 0);
      check(rd_beat == 0 && wr_beat == 0, "R10 beats in reset", rd_beat, 0);
      rst_n = 1'b1;
      chk_on = 1'b1;

      // R10: default CL3 AL0 BL4 without any load
      scen = "R10 default settings";
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(1, 1, 1, 1, 0, 0, 0, 0);
      drain();

      // R3 R4 R2 R11 R6 R7: every legal combination
      for (int al = 0; al <= 4; al++) begin
         for (int cl = 3; cl <= 7; cl++) begin
            for (int b = 0; b < 2; b++) begin
               scen = $sformatf("R11 sweep cl=%0d al=%0d bl8=%0d", cl, al, b);
               load(cl, al, b[0]);
               step(1, 0, 1, 0, 0, 0, 0, 0);
               idle_n((b != 0 ? 4 : 2) - 1);
               step(1, 0, 0, 0, 0, 0, 0, 0);
               idle_n(2);
               step(1, 1, 1, 1, 0, 0, 0, 0);
               idle_n((b != 0 ? 4 : 2) - 1);
               step(1, 1, 0, 0, 0, 0, 0, 0);
               drain();
            end
         end
      end

      // R8: write right behind a read lands on the read window
      scen = "R8 read-write overlap";
      load(5, 2, 1'b1);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(1, 1, 0, 1, 0, 0, 0, 0);
      drain();
      scen = "R8 same-type too close";
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(1, 0, 1, 0, 0, 0, 0, 0);
      drain();
      scen = "R8 legal turnaround";
      step(1, 0, 0, 0, 0, 0, 0, 0);
      idle_n(4);
      step(1, 1, 0, 0, 0, 0, 0, 0);
      drain();

      // R1: illegal CL or AL values are dropped
      scen = "R1 illegal CL=2";
      load(2, 0, 1'b0);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      drain();
      scen = "R1 illegal AL=5";
      load(3, 5, 1'b0);
      step(1, 1, 0, 0, 0, 0, 0, 0);
      drain();

      // R9: load while a burst is pending, or with a command, is ignored
      scen = "R9 load while busy";
      load(3, 0, 1'b0);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 7, 4, 1'b1);
      drain();
      step(1, 0, 0, 0, 0, 0, 0, 0);
      drain();
      scen = "R9 load with command";
      step(1, 1, 0, 0, 1, 6, 1, 1'b1);
      drain();
      step(1, 0, 0, 0, 0, 0, 0, 0);
      drain();

      idle_n(4);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule